// File: doc/BRIEF.md
# Multi-Latency Pipeline Hazard Interlock

This block is the issue control for an in-order pipeline whose stages run fetch, decode (register read and branch test), memory access, then load writeback alongside functional-unit execution, then ALU writeback. Memory access comes before execution, so loads and stores use a register's value directly as the data address, and an ALU instruction may take one operand from memory through such a register. The address register must therefore be ready when the instruction reaches the memory stage, while data operands are needed only at execute and branch sources at decode.

The block keeps one readiness countdown per architectural register, covering 32 integer and 32 floating-point registers. It holds the decode instruction whenever a source would not be ready by the stage that consumes it, when a new result would land before an older, slower write to the same register, or when a second divide arrives while the unpipelined divider is still busy. For each source it also reports where the value must come from: the register file, or the result path of the producing unit.

Top module: `hazard_interlock`

## Requirements
- R1: After reset every register is ready and the divider is free. With `dec_valid` low, `stall` and `issue` are 0 and all three selects read 0.
- R2: A data source for an instruction of kind integer ALU (0), FP add (1), FP multiply (2), FP divide (3) or load (4) stalls decode until that register's countdown is at most 2. The countdown drops by one per clock.
- R3: The address register (integer, `dec_addr`) and the data source of a store (kind 5) stall decode until their countdown is at most 1.
- R4: A branch (kind 6) stalls until its source countdown is 0. It then always reads the register file, so its select is 0.
- R5: On issue, a destination countdown loads with the producer latency: load 1, integer ALU 3, FP add 9, FP multiply 19, FP divide 61. For example, an FP add that reads an FP multiply result issued one cycle earlier stalls 17 cycles.
- R6: A select reads 0 (register file) when the source countdown is 0. Otherwise it reads the producer code: 1 load, 2 integer ALU, 3 FP add, 4 FP multiply, 5 FP divide. A select for a disabled source reads 0.
- R7: A divide cannot issue until 60 cycles after the previous divide issued. The second of two back-to-back divides stalls 59 cycles.
- R8: An instruction that writes a register stalls while that register's countdown exceeds the new latency. An FP add to a register just targeted by an FP multiply stalls 10 cycles.
- R9: Integer register 0 (code 0) is never marked busy.
- R10: Store, branch and jump (kinds 5, 6, 7) do not mark their destination field busy, even with `dec_dst_en` set.
- R11: With `dec_valid` low the block neither stalls nor issues, and no register becomes busy.
- Register codes are 6 bits: bit 5 selects the FP file and bits 4:0 the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_kind | input | 3 | Instruction kind code |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst | input | 6 | Destination register code |
| dec_addr_en | input | 1 | Instruction uses an address register |
| dec_addr | input | 5 | Integer address register index |
| dec_sa_en | input | 1 | First data source used |
| dec_sa | input | 6 | First data source code |
| dec_sb_en | input | 1 | Second data source used |
| dec_sb | input | 6 | Second data source code |
| stall | output | 1 | Hold decode this cycle |
| issue | output | 1 | Decode instruction advances at the next edge |
| addr_sel | output | 3 | Source select for the address register |
| sa_sel | output | 3 | Source select for the first data source |
| sb_sel | output | 3 | Source select for the second data source |

## Verification
A countdown that loads the wrong latency, or decays at the wrong rate, shows up as a wrong stall length on the very next dependent instruction. The error is therefore visible within one latency window, at most 61 cycles. A wrong producer tag shows up in the select in the cycle the consumer issues. A missed divider-busy or write-order check lets `issue` rise early, and that is seen on the first cycle of the blocked instruction. Every stall count and select is compared against values worked out from the stated latencies.

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int NREG     = 32,
  parameter int INT_CYC  = 2,
  parameter int FADD_STG = 8,
  parameter int FMUL_STG = 18,
  parameter int FDIV_CYC = 60
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_valid,
  input  logic [2:0]                dec_kind,
  input  logic                      dec_dst_en,
  input  logic [$clog2(NREG):0]     dec_dst,
  input  logic                      dec_addr_en,
  input  logic [$clog2(NREG)-1:0]   dec_addr,
  input  logic                      dec_sa_en,
  input  logic [$clog2(NREG):0]     dec_sa,
  input  logic                      dec_sb_en,
  input  logic [$clog2(NREG):0]     dec_sb,
  output logic                      stall,
  output logic                      issue,
  output logic [2:0]                addr_sel,
  output logic [2:0]                sa_sel,
  output logic [2:0]                sb_sel
);
  localparam int RW       = $clog2(NREG);
  localparam int IW       = RW + 1;
  localparam int NENT     = 2 * NREG;
  localparam int LAT_LOAD = 1;
  localparam int LAT_INT  = INT_CYC + 1;
  localparam int LAT_FADD = FADD_STG + 1;
  localparam int LAT_FMUL = FMUL_STG + 1;
  localparam int LAT_FDIV = FDIV_CYC + 1;
  localparam int CW       = $clog2(LAT_FDIV + 1);
  localparam int DW       = $clog2(FDIV_CYC + 1);

  localparam logic [2:0] K_INT = 3'd0, K_FADD = 3'd1, K_FMUL = 3'd2, K_FDIV = 3'd3;
  localparam logic [2:0] K_LOAD = 3'd4, K_STORE = 3'd5, K_BR = 3'd6;

  localparam logic [2:0] T_RF = 3'd0, T_LOAD = 3'd1, T_INT = 3'd2;
  localparam logic [2:0] T_FADD = 3'd3, T_FMUL = 3'd4, T_FDIV = 3'd5;

  logic [CW-1:0] cnt_q [NENT];
  logic [2:0]    tag_q [NENT];
  logic [DW-1:0] div_q;

  logic [IW-1:0] addr_idx;
  logic [CW-1:0] data_need, new_lat;
  logic [2:0]    new_tag;
  logic          writes_dst;
  logic          wait_a, wait_sa, wait_sb, wait_waw, wait_div;

  assign addr_idx = {1'b0, dec_addr};

  always_comb begin
    new_lat = '0;
    new_tag = T_RF;
    case (dec_kind)
      K_INT:  begin new_lat = CW'(LAT_INT);  new_tag = T_INT;  end
      K_FADD: begin new_lat = CW'(LAT_FADD); new_tag = T_FADD; end
      K_FMUL: begin new_lat = CW'(LAT_FMUL); new_tag = T_FMUL; end
      K_FDIV: begin new_lat = CW'(LAT_FDIV); new_tag = T_FDIV; end
      K_LOAD: begin new_lat = CW'(LAT_LOAD); new_tag = T_LOAD; end
      default: ;
    endcase
  end

  assign data_need  = (dec_kind == K_BR) ? CW'(0) : (dec_kind == K_STORE) ? CW'(1) : CW'(2);
  assign writes_dst = dec_dst_en && (dec_kind <= K_LOAD) && (dec_dst != '0);

  assign wait_a   = dec_addr_en && (cnt_q[addr_idx] > CW'(1));
  assign wait_sa  = dec_sa_en && (cnt_q[dec_sa] > data_need);
  assign wait_sb  = dec_sb_en && (cnt_q[dec_sb] > data_need);
  assign wait_waw = writes_dst && (cnt_q[dec_dst] > new_lat);
  assign wait_div = (dec_kind == K_FDIV) && (div_q > DW'(1));

  assign stall = dec_valid && (wait_a || wait_sa || wait_sb || wait_waw || wait_div);
  assign issue = dec_valid && !stall;

  assign addr_sel = (dec_addr_en && cnt_q[addr_idx] != '0) ? tag_q[addr_idx] : T_RF;
  assign sa_sel   = (dec_sa_en && cnt_q[dec_sa] != '0) ? tag_q[dec_sa] : T_RF;
  assign sb_sel   = (dec_sb_en && cnt_q[dec_sb] != '0) ? tag_q[dec_sb] : T_RF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        cnt_q[i] <= '0;
        tag_q[i] <= T_RF;
      end
      div_q <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (issue && writes_dst && dec_dst == IW'(i)) begin
          cnt_q[i] <= new_lat;
          tag_q[i] <= new_tag;
        end else if (cnt_q[i] != '0) begin
          cnt_q[i] <= cnt_q[i] - CW'(1);
        end
      end
      if (issue && dec_kind == K_FDIV) div_q <= DW'(FDIV_CYC);
      else if (div_q != '0)            div_q <= div_q - DW'(1);
    end
  end

  logic [DW-1:0] gap_q;
  logic          seen_div_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= '0;
      seen_div_q <= 1'b0;
    end else if (issue && dec_kind == K_FDIV) begin
      gap_q      <= '0;
      seen_div_q <= 1'b1;
    end else if (gap_q != DW'(FDIV_CYC)) begin
      gap_q <= gap_q + DW'(1);
    end
  end

  AST_LAT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && writes_dst) |=> cnt_q[$past(dec_dst)] == $past(new_lat)); // R5
  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_kind == K_FDIV && seen_div_q) |-> gap_q >= DW'(FDIV_CYC - 1)); // R7
  AST_RAW_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_sa_en && dec_kind <= K_LOAD) |-> cnt_q[dec_sa] <= CW'(2)); // R2
  AST_BRANCH_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_kind == K_BR && dec_sa_en) |-> sa_sel == T_RF); // R4
  AST_R0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[0] == '0); // R9
  AST_NO_WAW_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && writes_dst) |-> cnt_q[dec_dst] <= new_lat); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall && !issue); // R11
endmodule

// File: tb/hazard_interlock_tb.sv
`timescale 1ns/1ps
module hazard_interlock_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic [2:0] dec_kind = '0;
  logic dec_dst_en = 1'b0;
  logic [5:0] dec_dst = '0;
  logic dec_addr_en = 1'b0;
  logic [4:0] dec_addr = '0;
  logic dec_sa_en = 1'b0;
  logic [5:0] dec_sa = '0;
  logic dec_sb_en = 1'b0;
  logic [5:0] dec_sb = '0;
  logic stall, issue;
  logic [2:0] addr_sel, sa_sel, sb_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hazard_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .dec_dst_en(dec_dst_en), .dec_dst(dec_dst), .dec_addr_en(dec_addr_en),
    .dec_addr(dec_addr), .dec_sa_en(dec_sa_en), .dec_sa(dec_sa),
    .dec_sb_en(dec_sb_en), .dec_sb(dec_sb), .stall(stall), .issue(issue),
    .addr_sel(addr_sel), .sa_sel(sa_sel), .sb_sel(sb_sel)
  );

  typedef struct packed {
    logic [2:0] kind;
    logic [5:0] dst;
    logic       de;
    logic       ae;
    logic [4:0] ad;
    logic       sae;
    logic [5:0] sa;
    logic       sbe;
    logic [5:0] sb;
    logic [7:0] stalls;
    logic [2:0] asel;
    logic [2:0] sasel;
    logic [2:0] sbsel;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 6'd2,  1'b1, 1'b1, 5'd1, 1'b0, 6'd0,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd4, 6'd34, 1'b1, 1'b1, 5'd2, 1'b0, 6'd0,  1'b0, 6'd0,  8'd0,  3'd1, 3'd0, 3'd0},
    '{3'd2, 6'd33, 1'b1, 1'b0, 5'd0, 1'b1, 6'd34, 1'b1, 6'd36, 8'd0,  3'd0, 3'd1, 3'd0},
    '{3'd1, 6'd38, 1'b1, 1'b0, 5'd0, 1'b1, 6'd33, 1'b1, 6'd34, 8'd17, 3'd0, 3'd4, 3'd0},
    '{3'd5, 6'd0,  1'b0, 1'b1, 5'd4, 1'b1, 6'd38, 1'b0, 6'd0,  8'd8,  3'd0, 3'd3, 3'd0},
    '{3'd0, 6'd5,  1'b1, 1'b1, 5'd6, 1'b1, 6'd7,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd0, 6'd8,  1'b1, 1'b1, 5'd5, 1'b0, 6'd0,  1'b0, 6'd0,  8'd2,  3'd2, 3'd0, 3'd0},
    '{3'd6, 6'd0,  1'b0, 1'b0, 5'd0, 1'b1, 6'd8,  1'b0, 6'd0,  8'd3,  3'd0, 3'd0, 3'd0},
    '{3'd0, 6'd0,  1'b1, 1'b0, 5'd0, 1'b1, 6'd1,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd6, 6'd0,  1'b0, 1'b0, 5'd0, 1'b1, 6'd0,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd3, 6'd42, 1'b1, 1'b0, 5'd0, 1'b1, 6'd44, 1'b1, 6'd45, 8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd3, 6'd43, 1'b1, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 6'd0,  8'd59, 3'd0, 3'd0, 3'd0},
    '{3'd2, 6'd52, 1'b1, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd1, 6'd52, 1'b1, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 6'd0,  8'd10, 3'd0, 3'd0, 3'd0},
    '{3'd5, 6'd9,  1'b1, 1'b1, 5'd0, 1'b0, 6'd0,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0},
    '{3'd6, 6'd0,  1'b0, 1'b0, 5'd0, 1'b1, 6'd9,  1'b0, 6'd0,  8'd0,  3'd0, 3'd0, 3'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dec_valid = 1'b1; dec_kind = v.kind; dec_dst_en = v.de; dec_dst = v.dst;
    dec_addr_en = v.ae; dec_addr = v.ad; dec_sa_en = v.sae; dec_sa = v.sa;
    dec_sb_en = v.sbe; dec_sb = v.sb;
  endtask

  task automatic run(input vec_t v, input string req);
    int n;
    drive(v);
    n = 0;
    #1;
    while (stall && n < 300) begin
      @(negedge clk); #1;
      n++;
    end
    chk({req, " stall cycles"}, n, int'(v.stalls));
    chk({req, " issue"}, int'(issue), 1);
    chk({req, " addr_sel"}, int'(addr_sel), int'(v.asel));
    chk({req, " sa_sel"}, int'(sa_sel), int'(v.sasel));
    chk({req, " sb_sel"}, int'(sb_sel), int'(v.sbsel));
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tags [NV] = '{"R3 load addr", "R3 R6 addr forward", "R2 R6 load fwd",
      "R2 R5 R6 fmul wait", "R3 R6 store data", "R2 int issue", "R3 R5 R6 alum addr",
      "R4 branch", "R9 write r0", "R9 R4 r0 ready", "R1 R7 first div",
      "R7 second div", "R5 fmul", "R8 waw", "R10 store dst", "R10 dst unmarked"};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset stall", int'(stall), 0);
    chk("R1 reset issue", int'(issue), 0);
    chk("R1 reset sels", int'({addr_sel, sa_sel, sb_sel}), 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) run(VECS[i], tags[i]);

    dec_valid = 1'b0; dec_kind = 3'd2; dec_dst_en = 1'b1; dec_dst = 6'd62;
    dec_addr_en = 1'b0; dec_sa_en = 1'b0; dec_sb_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R11 idle stall", int'(stall), 0);
      chk("R11 idle issue", int'(issue), 0);
      @(negedge clk);
    end
    run('{3'd1, 6'd60, 1'b1, 1'b0, 5'd0, 1'b1, 6'd62, 1'b0, 6'd0, 8'd0, 3'd0, 3'd0, 3'd0},
        "R11 no mark");

    run('{3'd2, 6'd33, 1'b1, 1'b0, 5'd0, 1'b0, 6'd0, 1'b0, 6'd0, 8'd0, 3'd0, 3'd0, 3'd0},
        "R1 pre-reset fmul");
    dec_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run('{3'd1, 6'd39, 1'b1, 1'b0, 5'd0, 1'b1, 6'd33, 1'b0, 6'd0, 8'd0, 3'd0, 3'd0, 3'd0},
        "R1 reset clears");
    run('{3'd3, 6'd40, 1'b1, 1'b0, 5'd0, 1'b0, 6'd0, 1'b0, 6'd0, 8'd0, 3'd0, 3'd0, 3'd0},
        "R1 R7 div free");
    dec_valid = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule